// File: doc/BRIEF.md
# Debug Address Range Comparator

This block sits beside a bus that carries an 18-bit address stream and raises a flag when an access falls in a window set by a pair of limit comparators, A and B. The window can be read two ways. In inside mode an access counts when its address lies between the A limit and the B limit, both limits included. In outside mode each comparator watches one side: A flags addresses below its limit, B flags addresses above its limit, and either side alone is a valid hit.

Word accesses are aligned. An access marked as a word is judged only by its even address, with bit 0 cleared, so a word that crosses a limit is placed by where its aligned address falls. Each comparator either reports a forced match or requests an instruction tag. A forced match is a one-cycle pulse two clock cycles after the matching address cycle, whatever the read/write direction. With tagging selected, a match on an opcode fetch read gives a one-cycle tag request one cycle later and no forced pulse. A debug state machine would take these outputs as its qualifiers.

Top module: `dbg_range_cmp`

## Requirements
- R1: After reset, and until the first matching address cycle, `fm_pulse` and `tag_attach` are all zero.
- R2: With `cfg_outside`=1, channel 0 (comparator A) hits when the effective address is below `lim_a`, and channel 1 (comparator B) hits when it is above `lim_b`.
- R3: In outside mode the two sides are independent: a hit on one side drives its own channel alone, and each side alone is a complete match.
- R4: With `cfg_outside`=0, an effective address with `lim_a` <= address <= `lim_b` hits on channel 0 only; channel 1 never hits in inside mode.
- R5: The effective address is `bus_addr` with bit 0 cleared when `bus_word`=1, and `bus_addr` unchanged when `bus_word`=0; a word crossing a limit is judged by its even address.
- R6: In outside mode `lim_b`=0x3FFFF means channel 1 never hits and `lim_a`=0x00000 means channel 0 never hits.
- R7: A channel hit whose tag select is 0 gives a one-cycle `fm_pulse` bit exactly two clock cycles after the address cycle, whatever the value of `bus_rd` or `bus_fetch`.
- R8: A channel hit whose tag select is 1 (`cfg_tag_a` for channel 0, `cfg_tag_b` for channel 1), on a cycle with `bus_fetch`=1 and `bus_rd`=1, sets that channel's `tag_attach` bit for exactly the one cycle after the address cycle, and gives no `fm_pulse`.
- R9: A hit on a tagging channel when `bus_fetch`=0 or `bus_rd`=0 gives neither a tag request nor a forced pulse.
- R10: A comparator whose enable (`cfg_en_a`, `cfg_en_b`) is 0 never hits; in inside mode both enables must be 1 for channel 0 to hit.
- R11: A cycle with `bus_valid`=0 never produces a hit on either channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_valid | input | 1 | Address cycle present |
| bus_addr | input | 18 | Access address |
| bus_word | input | 1 | 1 = aligned word access, 0 = byte |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_fetch | input | 1 | Opcode fetch strobe |
| cfg_outside | input | 1 | 1 = outside-range mode, 0 = inside-range mode |
| cfg_en_a | input | 1 | Enable of comparator A |
| cfg_en_b | input | 1 | Enable of comparator B |
| cfg_tag_a | input | 1 | Comparator A: 1 = tag fetched opcodes, 0 = forced match |
| cfg_tag_b | input | 1 | Comparator B: 1 = tag fetched opcodes, 0 = forced match |
| lim_a | input | 18 | Lower limit (comparator A) |
| lim_b | input | 18 | Upper limit (comparator B) |
| fm_pulse | output | 2 | Forced-match pulse, bit 0 = channel A, bit 1 = channel B |
| tag_attach | output | 2 | Tag request, bit 0 = channel A, bit 1 = channel B |

## Verification
On every cycle the assertions check the two-cycle forced-match delay from each channel's request, that a tag request only follows a fetch read, that an idle bus cycle yields no output, that channel B stays quiet in inside mode or when its limit sits at the top of the address space, and that a disabled comparator never hits. What only the bench's sweeps can show is the arithmetic of the window itself: the exact inclusive and exclusive edges at each limit, the placement of a word that straddles a limit by its even address, and the mapping from each mode, enable and tag setting to the right output bit.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;

   typedef enum logic {
      SIDE_LOW  = 1'b0,
      SIDE_HIGH = 1'b1
   } side_e;

   localparam int unsigned NUM_CH = 2;
   localparam int unsigned CH_A   = 0;
   localparam int unsigned CH_B   = 1;

endpackage

// File: rtl/dbg_addr_align.sv
module dbg_addr_align #(
   parameter int unsigned ADDR_W = 18
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              word_i,
   output logic [ADDR_W-1:0] eff_o
);

   localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-1){1'b1}}, 1'b0};

   if (ADDR_W < 2) begin : g_bad_width
      $error("dbg_addr_align: ADDR_W must be at least 2");
   end

   always_comb begin
      if (word_i) eff_o = addr_i & ALIGN_MASK;
      else        eff_o = addr_i;
   end

   always_comb begin
      if (word_i) begin
         a_r5_even_word: assert (eff_o[0] == 1'b0);
      end
   end

endmodule

// File: rtl/dbg_limit_cmp.sv
module dbg_limit_cmp #(
   parameter int unsigned          ADDR_W = 18,
   parameter dbg_cmp_pkg::side_e   SIDE   = dbg_cmp_pkg::SIDE_LOW
) (
   input  logic [ADDR_W-1:0] eff_i,
   input  logic [ADDR_W-1:0] lim_i,
   output logic              beyond_o,
   output logic              within_o
);

   if (SIDE == dbg_cmp_pkg::SIDE_LOW) begin : g_low
      always_comb begin
         beyond_o = eff_i < lim_i;
         within_o = !beyond_o;
      end
   end else begin : g_high
      always_comb begin
         beyond_o = eff_i > lim_i;
         within_o = !beyond_o;
      end
   end

endmodule

// File: rtl/dbg_pulse_pipe.sv
module dbg_pulse_pipe #(
   parameter int unsigned LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (LAT < 1 || LAT > 8) begin : g_bad_lat
      $error("dbg_pulse_pipe: LAT must lie in 1..8");
   end

   logic [LAT-1:0] stage_q;

   for (genvar s = 0; s < LAT; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= 1'b0;
            else        stage_q[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= 1'b0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign dout = stage_q[LAT-1];

endmodule

// File: rtl/dbg_chan_out.sv
module dbg_chan_out #(
   parameter int unsigned FM_LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   input  logic tag_sel_i,
   input  logic fetch_rd_i,
   output logic fm_pulse_o,
   output logic tag_o
);

   logic fm_req;
   logic tag_req;

   always_comb begin
      fm_req  = hit_i && !tag_sel_i;
      tag_req = hit_i && tag_sel_i && fetch_rd_i;
   end

   dbg_pulse_pipe #(
      .LAT (FM_LAT)
   ) i_fm_pipe (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (fm_req),
      .dout (fm_pulse_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) tag_o <= 1'b0;
      else        tag_o <= tag_req;
   end

   if (FM_LAT == 2) begin : g_lat_chk
      a_r7_fm_after_two: assert property (@(posedge clk) disable iff (!rst_n)
         fm_req |-> ##2 fm_pulse_o);
      a_r7_fm_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n, 2) && fm_pulse_o |-> $past(fm_req, 2));
   end

   a_r8_tag_from_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && tag_o |-> $past(fetch_rd_i) && $past(tag_sel_i));

   a_r9_no_tag_without_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_rd_i |=> !tag_o);

endmodule

// File: rtl/dbg_range_cmp.sv
module dbg_range_cmp #(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned FM_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_word,
   input  logic              bus_rd,
   input  logic              bus_fetch,
   input  logic              cfg_outside,
   input  logic              cfg_en_a,
   input  logic              cfg_en_b,
   input  logic              cfg_tag_a,
   input  logic              cfg_tag_b,
   input  logic [ADDR_W-1:0] lim_a,
   input  logic [ADDR_W-1:0] lim_b,
   output logic [1:0]        fm_pulse,
   output logic [1:0]        tag_attach
);

   import dbg_cmp_pkg::*;

   localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

   if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr_w
      $error("dbg_range_cmp: ADDR_W must lie in 2..32");
   end
   if (FM_LAT < 1) begin : g_bad_fm_lat
      $error("dbg_range_cmp: FM_LAT must be at least 1");
   end

   logic [ADDR_W-1:0] eff_addr;
   logic              below_a, above_b;
   logic              ge_a, le_b;
   logic              in_window;
   logic [NUM_CH-1:0] hit;
   logic [NUM_CH-1:0] tag_sel;
   logic              fetch_rd;

   dbg_addr_align #(
      .ADDR_W(ADDR_W)
   ) i_align (
      .addr_i(bus_addr),
      .word_i(bus_word),
      .eff_o (eff_addr)
   );

   dbg_limit_cmp #(
      .ADDR_W(ADDR_W),
      .SIDE  (SIDE_LOW)
   ) i_cmp_a (
      .eff_i   (eff_addr),
      .lim_i   (lim_a),
      .beyond_o(below_a),
      .within_o(ge_a)
   );

   dbg_limit_cmp #(
      .ADDR_W(ADDR_W),
      .SIDE  (SIDE_HIGH)
   ) i_cmp_b (
      .eff_i   (eff_addr),
      .lim_i   (lim_b),
      .beyond_o(above_b),
      .within_o(le_b)
   );

   always_comb begin
      in_window = ge_a && le_b;
      hit       = '0;
      if (bus_valid) begin
         if (cfg_outside) begin
            hit[CH_A] = cfg_en_a && below_a;
            hit[CH_B] = cfg_en_b && above_b;
         end else begin
            hit[CH_A] = cfg_en_a && cfg_en_b && in_window;
         end
      end
      tag_sel  = {cfg_tag_b, cfg_tag_a};
      fetch_rd = bus_fetch && bus_rd;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      dbg_chan_out #(
         .FM_LAT(FM_LAT)
      ) i_out (
         .clk       (clk),
         .rst_n     (rst_n),
         .hit_i     (hit[c]),
         .tag_sel_i (tag_sel[c]),
         .fetch_rd_i(fetch_rd),
         .fm_pulse_o(fm_pulse[c]),
         .tag_o     (tag_attach[c])
      );
   end

   a_r4_inside_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_outside |-> !hit[CH_B]);

   a_r6_top_limit_off: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_outside && lim_b == ADDR_TOP |-> !hit[CH_B]);

   a_r6_bottom_limit_off: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_outside && lim_a == '0 |-> !hit[CH_A]);

   a_r10_disabled_a: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en_a |-> !hit[CH_A]);

   a_r10_disabled_b: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en_b |-> hit == '0 || (cfg_outside && hit == 2'b01));

   a_r11_idle_no_tag: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> tag_attach == '0);

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> fm_pulse == '0 && tag_attach == '0);

endmodule

// File: tb/test_dbg_range_cmp.sv
module test_dbg_range_cmp;

   localparam int AW = 18;
   localparam logic [AW-1:0] TOP = 18'h3FFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_word = 1'b0;
   logic          bus_rd = 1'b0;
   logic          bus_fetch = 1'b0;
   logic          cfg_outside = 1'b0;
   logic          cfg_en_a = 1'b0;
   logic          cfg_en_b = 1'b0;
   logic          cfg_tag_a = 1'b0;
   logic          cfg_tag_b = 1'b0;
   logic [AW-1:0] lim_a = '0;
   logic [AW-1:0] lim_b = '0;
   logic [1:0]    fm_pulse;
   logic [1:0]    tag_attach;

   int checks = 0;
   int errors = 0;
   logic [1:0] ef1 = '0, ef2 = '0, et1 = '0;

   always #4 clk = ~clk;

   dbg_range_cmp #(.ADDR_W(AW), .FM_LAT(2)) i_dbg_range_cmp (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
      .bus_word(bus_word), .bus_rd(bus_rd), .bus_fetch(bus_fetch),
      .cfg_outside(cfg_outside), .cfg_en_a(cfg_en_a), .cfg_en_b(cfg_en_b),
      .cfg_tag_a(cfg_tag_a), .cfg_tag_b(cfg_tag_b), .lim_a(lim_a), .lim_b(lim_b),
      .fm_pulse(fm_pulse), .tag_attach(tag_attach)
   );

   task automatic check2(input string req, input string what,
                         input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s addr=%h word=%0d actual=%b expected=%b",
                  req, what, bus_addr, bus_word, act, exp);
      end
   endtask

   function automatic logic [1:0] model_hit();
      logic [AW-1:0] eff;
      logic [1:0] h;
      eff = bus_word ? {bus_addr[AW-1:1], 1'b0} : bus_addr;
      h = 2'b00;
      if (bus_valid) begin
         if (cfg_outside) begin
            h[0] = cfg_en_a && (eff < lim_a);
            h[1] = cfg_en_b && (eff > lim_b);
         end else begin
            h[0] = cfg_en_a && cfg_en_b && (eff >= lim_a) && (eff <= lim_b);
         end
      end
      return h;
   endfunction

   // one address cycle; inputs are already set at a falling edge
   task automatic step(input string req);
      logic [1:0] h, ef, et, tg;
      h  = model_hit();
      tg = {cfg_tag_b, cfg_tag_a};
      ef = h & ~tg;
      et = (bus_fetch && bus_rd) ? (h & tg) : 2'b00;
      @(posedge clk);
      ef2 = ef1; ef1 = ef; et1 = et;
      @(negedge clk);
      check2(req, "fm_pulse(R7)", fm_pulse, ef2);
      check2(req, "tag_attach(R8)", tag_attach, et1);
   endtask

   task automatic sweep(input string req);
      logic [AW-1:0] pts [12];
      pts[0] = lim_a - 18'd2; pts[1] = lim_a - 18'd1; pts[2] = lim_a;
      pts[3] = lim_a + 18'd1; pts[4] = lim_a + 18'd2; pts[5] = lim_b - 18'd1;
      pts[6] = lim_b; pts[7] = lim_b + 18'd1; pts[8] = lim_b + 18'd2;
      pts[9] = '0; pts[10] = TOP; pts[11] = 18'd1;
      for (int p = 0; p < 12; p++) begin
         for (int m = 0; m < 8; m++) begin
            bus_addr  = pts[p];
            bus_word  = m[0];
            bus_rd    = m[1];
            bus_fetch = m[2];
            step(req);
         end
      end
   endtask

   task automatic set_cfg(input logic outside, input logic ea, input logic eb,
                          input logic ta, input logic tb,
                          input logic [AW-1:0] la, input logic [AW-1:0] lb);
      cfg_outside = outside; cfg_en_a = ea; cfg_en_b = eb;
      cfg_tag_a = ta; cfg_tag_b = tb; lim_a = la; lim_b = lb;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: outputs quiet in reset even with a matching cycle on the bus
      set_cfg(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 18'h00100, 18'h00200);
      bus_valid = 1'b1; bus_addr = 18'h00010;
      @(negedge clk);
      check2("R1", "fm_pulse in reset", fm_pulse, 2'b00);
      check2("R1", "tag_attach in reset", tag_attach, 2'b00);
      bus_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check2("R1", "fm_pulse after reset", fm_pulse, 2'b00);
      check2("R1", "tag_attach after reset", tag_attach, 2'b00);

      bus_valid = 1'b1;
      // R2, R3, R5: outside mode, both sides forced; odd limit edges for straddling words
      set_cfg(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 18'h00101, 18'h00200);
      sweep("R2_R3_R5");
      // R5: even upper limit so a word at limit+1 aligns back inside
      set_cfg(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 18'h00100, 18'h00300);
      sweep("R5");
      // R4: inside mode
      set_cfg(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 18'h00101, 18'h00200);
      sweep("R4");
      set_cfg(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 18'h00000, TOP);
      sweep("R4");
      // R6: limits at the ends of the address space
      set_cfg(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 18'h00000, TOP);
      sweep("R6");
      // R8, R9: tagging on one or both channels
      set_cfg(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 18'h00100, 18'h00200);
      sweep("R8_R9");
      set_cfg(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 18'h00100, 18'h00200);
      sweep("R8_R9");
      set_cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 18'h00100, 18'h00200);
      sweep("R8_R9");
      // R10: enables
      set_cfg(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 18'h00100, 18'h00200);
      sweep("R10");
      set_cfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 18'h00100, 18'h00200);
      sweep("R10");
      set_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 18'h00100, 18'h00200);
      sweep("R10");
      // R11: no valid cycle
      bus_valid = 1'b0;
      set_cfg(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 18'h00100, 18'h00200);
      sweep("R11");
      bus_valid = 1'b1;
      // R7, R8: lone events followed by idle cycles show exact timing and width
      set_cfg(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 18'h00100, 18'h00200);
      bus_addr = 18'h00050; bus_rd = 1'b0; bus_fetch = 1'b0; bus_word = 1'b0;
      step("R7");
      bus_valid = 1'b0;
      for (int k = 0; k < 3; k++) step("R7");
      bus_valid = 1'b1; bus_addr = 18'h00300; bus_rd = 1'b1; bus_fetch = 1'b1;
      step("R8");
      bus_valid = 1'b0;
      for (int k = 0; k < 3; k++) step("R8");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule